// File: doc/BRIEF.md
# Status Flag Unit with Guarded Flags Register

This block keeps a 32-bit processor status word up to date. Each cycle in which `upd_en` is high, it looks at the two operands, the result the datapath produced, and the kind of operation. From these it recomputes the six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. All other fields of the word are left as they were. A small command port works alongside this. It can set, clear or complement the carry flag, set or clear the direction flag, and load the whole word from `wr_data`. How much of a whole-word load lands depends on the privilege level on `cpl`.

The operand width is the parameter `W`, with a default of 32 and a minimum of 4. Parity is taken over the low eight bits of the result, or over all `W` bits when `W` is below eight. Updates are accepted on every cycle. There is no handshake and no back-pressure: the datapath holds `upd_en` high for exactly the cycles whose results should reach the flags. Every input acts at the next rising clock edge, and `flags` is a register output.

Top module: `sfu_status_reg`

## Requirements
- R1: After reset `flags` reads 0x00000002.
- R2: Bit 1 always reads 1. Bits 3, 5, 14 to 20 and 22 to 31 always read 0. No write or update changes any of these bits.
- R3: On an update, CF (bit 0) is set when the operation carries out of bit W-1 (op_kind 0, add) or borrows out of it (op_kind 1, subtract, a minus b, i.e. a < b unsigned). Otherwise CF is cleared.
- R4: On an update, PF (bit 2) is 1 when the low min(8,W) bits of `result` hold an even number of ones. ZF (bit 6) is 1 when `result` is zero. SF (bit 7) equals `result[W-1]`.
- R5: On an update, AF (bit 4) is set on a carry (add) or a borrow (subtract) out of bit 3. AF is cleared for logic operations (op_kind 2 or 3).
- R6: On an update, OF (bit 11) is set when `op_a` and the effective second operand have the same sign and `result` has the other sign. The effective second operand is `op_b` for add and its bitwise complement for subtract. Logic operations clear OF and CF.
- R7: With `upd_en` low and `cmd` a no-op (0 or 7), `flags` holds its value. An arithmetic update never changes TF (bit 8), IF (bit 9), DF (bit 10), IOPL (bits 13:12) or ID (bit 21).
- R8: `cmd` 1, 2 and 3 set, clear and complement CF at the next edge. They act on the CF value that a same-cycle update produces, and they leave the other bits of that update intact.
- R9: `cmd` 4 sets DF and `cmd` 5 clears DF. Any same-cycle arithmetic update still applies.
- R10: `cmd` 6 loads bits 0, 2, 4, 6 to 11 and 21 from `wr_data`. It loads IOPL (bits 13:12) only when `cpl` is 0; otherwise IOPL keeps its value. This load takes precedence over a same-cycle arithmetic update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (subtrahend for subtract) |
| result | input | W | Result produced by the datapath |
| op_kind | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| upd_en | input | 1 | Recompute the arithmetic flags this cycle |
| cmd | input | 3 | 0 none, 1 CF set, 2 CF clear, 3 CF complement, 4 DF set, 5 DF clear, 6 word load, 7 none |
| wr_data | input | 32 | Word for a load command |
| cpl | input | 2 | Current privilege level |
| flags | output | 32 | Status word |

## Verification
The bench builds the unit with W=4 and drives every pair of operands through add, subtract and both logic codes. The add and subtract sweeps cover every carry, borrow, nibble-carry and signed-overflow boundary, so a wrong comparison edge or a sign test inverted only for subtraction shows up as a mismatch. The logic sweeps show that CF, AF and OF clear while PF, ZF and SF still follow the result. Before the sweeps, a load sets TF, IF and ID. Because the sweeps never touch these bits, any arithmetic update that leaks into non-arithmetic fields is caught. Directed steps then combine commands with updates in the same cycle and load the word at several privilege levels, which separates command precedence from the IOPL guard.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [1:0] {
    OP_ADD       = 2'd0,
    OP_SUB       = 2'd1,
    OP_LOGIC     = 2'd2,
    OP_LOGIC_ALT = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_CF_SET   = 3'd1,
    CMD_CF_CLR   = 3'd2,
    CMD_CF_INV   = 3'd3,
    CMD_DF_SET   = 3'd4,
    CMD_DF_CLR   = 3'd5,
    CMD_LOAD     = 3'd6,
    CMD_NONE_ALT = 3'd7
  } cmd_e;

  localparam int POS_CF   = 0;
  localparam int POS_PF   = 2;
  localparam int POS_AF   = 4;
  localparam int POS_ZF   = 6;
  localparam int POS_SF   = 7;
  localparam int POS_DF   = 10;
  localparam int POS_OF   = 11;
  localparam int POS_IOPL = 12;

  localparam logic [31:0] WORD_RESET   = 32'h0000_0002;
  localparam logic [31:0] WORD_ONES    = 32'h0000_0002;
  localparam logic [31:0] MASK_ARITH   = 32'h0000_08D5;
  localparam logic [31:0] MASK_LOADABL = 32'h0020_0FD5;
  localparam logic [31:0] MASK_IOPL    = 32'h0000_3000;
  localparam logic [31:0] MASK_LIVE    = MASK_LOADABL | MASK_IOPL;

endpackage

// File: rtl/sfu_arith_flags.sv
module sfu_arith_flags
  import sfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  input  op_kind_e     kind,
  output logic [31:0]  arith_word
);
  localparam int PW = (W < 8) ? W : 8;

  if (W < 4) begin : g_width_check
    $error("sfu_arith_flags needs W of at least 4");
  end

  logic         is_add, is_sub;
  logic [W-1:0] b_eff;
  logic         carry, aux, ovf;

  always_comb begin
    is_add = (kind == OP_ADD);
    is_sub = (kind == OP_SUB);
    b_eff  = is_sub ? ~b : b;
    carry  = 1'b0;
    aux    = 1'b0;
    if (is_add) begin
      carry = ({1'b0, a} + {1'b0, b}) > {1'b0, {W{1'b1}}};
      aux   = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
    end else if (is_sub) begin
      carry = a < b;
      aux   = a[3:0] < b[3:0];
    end
    ovf = (is_add || is_sub) && (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);

    arith_word         = '0;
    arith_word[POS_CF] = carry;
    arith_word[POS_PF] = ~^res[PW-1:0];
    arith_word[POS_AF] = aux;
    arith_word[POS_ZF] = (res == '0);
    arith_word[POS_SF] = res[W-1];
    arith_word[POS_OF] = ovf;
  end

endmodule

// File: rtl/sfu_write_mask.sv
module sfu_write_mask
  import sfu_pkg::*;
(
  input  logic [31:0] cur,
  input  logic [31:0] wdata,
  input  logic [1:0]  cpl,
  output logic [31:0] merged
);
  logic [31:0] allowed;

  always_comb begin
    allowed = MASK_LOADABL | ((cpl == 2'd0) ? MASK_IOPL : 32'h0);
    merged  = (wdata & allowed) | (cur & ~allowed);
  end

endmodule

// File: rtl/sfu_status_reg.sv
module sfu_status_reg
  import sfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] result,
  input  logic [1:0]   op_kind,
  input  logic         upd_en,
  input  logic [2:0]   cmd,
  input  logic [31:0]  wr_data,
  input  logic [1:0]   cpl,
  output logic [31:0]  flags
);
  logic [31:0] flags_q, flags_d;
  logic [31:0] arith_word, load_word;
  cmd_e        cmd_k;

  assign cmd_k = cmd_e'(cmd);

  sfu_arith_flags #(.W(W)) u_arith (
    .a          (op_a),
    .b          (op_b),
    .res        (result),
    .kind       (op_kind_e'(op_kind)),
    .arith_word (arith_word)
  );

  sfu_write_mask u_wmask (
    .cur    (flags_q),
    .wdata  (wr_data),
    .cpl    (cpl),
    .merged (load_word)
  );

  always_comb begin
    flags_d = flags_q;
    if (cmd_k == CMD_LOAD) begin
      flags_d = load_word;
    end else begin
      if (upd_en) flags_d = (flags_q & ~MASK_ARITH) | arith_word;
      case (cmd_k)
        CMD_CF_SET: flags_d[POS_CF] = 1'b1;
        CMD_CF_CLR: flags_d[POS_CF] = 1'b0;
        CMD_CF_INV: flags_d[POS_CF] = ~flags_d[POS_CF];
        CMD_DF_SET: flags_d[POS_DF] = 1'b1;
        CMD_DF_CLR: flags_d[POS_DF] = 1'b0;
        default: ;
      endcase
    end
    flags_d = (flags_d & MASK_LIVE) | WORD_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= WORD_RESET;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && (cmd == 3'd0 || cmd == 3'd7)) |=> $stable(flags)); // R7
  AST_IOPL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6 && cpl != 2'd0) |=> flags[13:12] == $past(flags[13:12])); // R10
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_kind[1] && cmd == 3'd0) |=> (!flags[POS_CF] && !flags[POS_OF] && !flags[POS_AF])); // R6
  AST_CF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |=> flags[POS_CF]); // R8
  AST_CF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 && !upd_en) |=> flags[POS_CF] != $past(flags[POS_CF])); // R8
  AST_DF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4) |=> flags[POS_DF]); // R9
  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && cmd == 3'd0) |=> flags[POS_ZF] == ($past(result) == '0)); // R4
  AST_RESERVED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6) |=> (flags[1] && flags[31:22] == '0 && flags[20:14] == '0)); // R2

endmodule

// File: tb/test_sfu_status_reg.sv
module test_sfu_status_reg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, result = '0;
  logic [1:0]   op_kind = '0;
  logic         upd_en = 1'b0;
  logic [2:0]   cmd = '0;
  logic [31:0]  wr_data = '0;
  logic [1:0]   cpl = '0;
  logic [31:0]  flags;

  int n_run = 0, n_fail = 0;
  logic [31:0] expv;

  always #10 clk = ~clk;

  sfu_status_reg #(.W(W)) i_sfu_status_reg (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result),
    .op_kind(op_kind), .upd_en(upd_en), .cmd(cmd), .wr_data(wr_data),
    .cpl(cpl), .flags(flags)
  );

  function automatic logic [31:0] model_arith(int a, int b, int k, int r);
    logic [31:0] w = '0;
    int sa = (a >= 8) ? a - 16 : a;
    int sb = (b >= 8) ? b - 16 : b;
    int ones = 0, sv;
    for (int i = 0; i < 4; i++) ones += (r >> i) & 1;
    w[2] = (ones % 2) == 0;
    w[6] = (r == 0);
    w[7] = r >= 8;
    if (k == 0) begin
      w[0] = (a + b) > 15;
      w[4] = ((a % 16) + (b % 16)) > 15;
      sv = sa + sb;
      w[11] = (sv > 7) || (sv < -8);
    end else if (k == 1) begin
      w[0] = a < b;
      w[4] = a < b;
      sv = sa - sb;
      w[11] = (sv > 7) || (sv < -8);
    end
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] want);
    n_run++;
    if (flags !== want) begin
      n_fail++;
      $display("FAIL %s: flags=%h expected=%h", tag, flags, want);
    end
  endtask

  task automatic step(int a, int b, int r, int k, logic u, logic [2:0] c,
                      logic [31:0] wd, logic [1:0] pl);
    op_a = a[W-1:0]; op_b = b[W-1:0]; result = r[W-1:0];
    op_kind = k[1:0]; upd_en = u; cmd = c; wr_data = wd; cpl = pl;
    @(posedge clk);
    @(negedge clk);
    upd_en = 1'b0; cmd = 3'd0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: flags=%h expected=completion", flags);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0000_0002);
    rst_n = 1'b1;
    @(negedge clk);

    step(0, 0, 0, 0, 0, 3'd6, 32'hFFFF_FFFF, 2'd0);
    check("R2 R10 full load", 32'h0020_3FD7);
    step(0, 0, 0, 0, 0, 3'd6, 32'h0, 2'd3);
    check("R10 iopl kept", 32'h0000_3002);
    step(0, 0, 0, 0, 0, 3'd6, 32'h0, 2'd0);
    check("R10 iopl cleared", 32'h0000_0002);
    step(0, 0, 0, 0, 0, 3'd6, 32'hFFDF_F02A, 2'd2);
    check("R2 reserved ignore", 32'h0000_0002);
    step(0, 0, 0, 0, 0, 3'd6, 32'h0020_1300, 2'd0);
    expv = 32'h0020_1302;
    check("R10 setup", expv);

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          int r;
          case (k)
            0: r = (a + b) % 16;
            1: r = (a - b + 16) % 16;
            2: r = a ^ b;
            default: r = a | b;
          endcase
          step(a, b, r, k, 1'b1, 3'd0, 32'h0, 2'd0);
          expv = (expv & ~32'h0000_08D5) | model_arith(a, b, k, r);
          if (k == 0) check("R3 R4 R5 R6 R7 add", expv);
          else if (k == 1) check("R3 R4 R5 R6 R7 sub", expv);
          else check("R4 R6 logic", expv);
        end

    step(9, 9, 0, 1, 1'b1, 3'd0, 32'h0, 2'd0);
    expv = 32'h0020_1346;
    check("R4 zero result", expv);
    step(15, 1, 0, 0, 1'b0, 3'd0, 32'h0, 2'd0);
    check("R7 idle hold", expv);
    step(15, 1, 0, 0, 1'b0, 3'd7, 32'h0, 2'd0);
    check("R7 alt no-op", expv);

    step(0, 0, 0, 0, 0, 3'd1, 32'h0, 2'd0);
    expv[0] = 1'b1; check("R8 cf set", expv);
    step(0, 0, 0, 0, 0, 3'd3, 32'h0, 2'd0);
    expv[0] = 1'b0; check("R8 cf flip low", expv);
    step(0, 0, 0, 0, 0, 3'd3, 32'h0, 2'd0);
    expv[0] = 1'b1; check("R8 cf flip high", expv);
    step(0, 0, 0, 0, 0, 3'd2, 32'h0, 2'd0);
    expv[0] = 1'b0; check("R8 cf clear", expv);
    step(1, 2, 3, 0, 1'b1, 3'd1, 32'h0, 2'd0);
    expv = (expv & ~32'h0000_08D5) | model_arith(1, 2, 0, 3);
    expv[0] = 1'b1; check("R8 set with update", expv);
    step(15, 1, 0, 0, 1'b1, 3'd3, 32'h0, 2'd0);
    expv = (expv & ~32'h0000_08D5) | model_arith(15, 1, 0, 0);
    expv[0] = 1'b0; check("R8 flip with update", expv);

    step(0, 0, 0, 0, 0, 3'd4, 32'h0, 2'd0);
    expv[10] = 1'b1; check("R9 df set", expv);
    step(8, 8, 0, 0, 1'b1, 3'd5, 32'h0, 2'd0);
    expv = (expv & ~32'h0000_08D5) | model_arith(8, 8, 0, 0);
    expv[10] = 1'b0; check("R9 df clear with update", expv);

    step(7, 1, 8, 0, 1'b1, 3'd6, 32'h0000_0001, 2'd1);
    expv = 32'h0000_1003;
    check("R10 load beats update", expv);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule